// File: doc/BRIEF.md
# Message-Interrupt Pending Register Front End

This block is the per-core register slave for message-signalled interrupts, whose identifiers start at 8192. A 64-bit register bus reaches a global enable, the base address and identifier width of the configuration table, and the base address of the pending table. The pending state for every identifier is kept in external memory as a bitmap, one bit per identifier.

A set-pending or clear-pending write becomes a byte read-modify-write on a byte-wide memory port. The block fetches the byte that holds the addressed bit. It writes the byte back only when the bit actually changes. After such a write it raises a one-cycle `rescan` pulse, which tells the priority selector to look at the bitmap again. While the memory transaction runs, the register bus is stalled through `reg_ready`, so only one transaction is outstanding at a time.

The control path is a four-state machine:
- IDLE: the bus is served. A register access completes in the same cycle. An accepted set or clear takes the transition *go* to FETCH.
- FETCH: a byte read is held until `mem_ready`. Then *need_write* leads to STORE, or *no_change* leads to FINISH.
- STORE: a byte write is held until `mem_ready`, then the machine moves to FINISH.
- FINISH: the bus access completes and `rescan` pulses if a write took place. The transition *back* leads to IDLE.

Top module: `msgirq_pend_front`

## Requirements
- R1: The offsets are decoded on the full address:
  - control 0x00
  - set-pending 0x40 and clear-pending 0x48
  - properties base 0x70 and pending base 0x78
  - invalidate-one 0xA0, invalidate-all 0xB0 and synchronize 0xC0

  Synchronize, invalidate, set and clear read as zero. Invalidate writes complete without error and change no state.
- R2: Control bit 0 is the enable. It reads back as written, and all other control bits read as zero.
- R3: A properties-base write keeps data bits 51:12 as the address and bits 4:0 as the identifier width. A width above 15 is stored as 15. A read returns the address ORed with the width.
- R4: A pending-base write keeps only data bits 51:16, and a read returns that value.
- R5: While the enable is 0, set and clear writes complete in the request cycle. They cause no memory access and no rescan.
- R6: A set or clear whose identifier (data bits 31:0) exceeds 2^(width+1) completes at once, with no memory access and no rescan. An identifier equal to that limit is accepted.
- R7: The bit for identifier n is at byte address pending-base + n/8, bit n mod 8. A set makes that bit 1, a clear makes it 0, and the other seven bits of the byte keep their values.
- R8: A set of a bit that is already 1, or a clear of a bit that is already 0, performs the byte read but no memory write.
- R9: `rescan` is high for exactly one cycle, in the cycle the bus access completes, and only after a memory write.
- R10: During a read-modify-write, `reg_ready` stays low until the final cycle. Memory request, address and direction are held while `mem_ready` is low.
- R11: Reset clears the enable, both base addresses and the identifier width.
- R12: An access to any other address reads zero and changes no state. `reg_err` is high for the single completing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until ready |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_ready | output | 1 | Access completes at this clock edge |
| reg_rdata | output | 64 | Read data, valid with reg_ready |
| reg_err | output | 1 | Undefined offset, valid with reg_ready |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 52 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or returns the byte at this edge |
| rescan | output | 1 | One-cycle pulse after the pending bitmap changed |

## Verification
The assertions rely on the bus master holding `reg_req` and its address and data steady until `reg_ready`, then dropping the request after one completion. They also rely on memory returning a valid byte in the cycle it raises `mem_ready`. The bench drives each access from a task that keeps all fields constant until the completing edge and withdraws the request straight after it. Its memory model answers only a live request, with a latency that varies from access to access, and presents read data together with ready.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_FINISH
    } rmw_state_e;

    typedef enum logic [3:0] {
        RG_CTRL,
        RG_SETP,
        RG_CLRP,
        RG_PROP,
        RG_PEND,
        RG_INV1,
        RG_INVALL,
        RG_SYNC,
        RG_NONE
    } reg_sel_e;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_SETP   = 8'h40;
    localparam logic [7:0] OFF_CLRP   = 8'h48;
    localparam logic [7:0] OFF_PROP   = 8'h70;
    localparam logic [7:0] OFF_PEND   = 8'h78;
    localparam logic [7:0] OFF_INV1   = 8'hA0;
    localparam logic [7:0] OFF_INVALL = 8'hB0;
    localparam logic [7:0] OFF_SYNC   = 8'hC0;

endpackage

// File: rtl/mpf_decode.sv
module mpf_decode
    import mpf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_CTRL):   sel = RG_CTRL;
            ADDR_W'(OFF_SETP):   sel = RG_SETP;
            ADDR_W'(OFF_CLRP):   sel = RG_CLRP;
            ADDR_W'(OFF_PROP):   sel = RG_PROP;
            ADDR_W'(OFF_PEND):   sel = RG_PEND;
            ADDR_W'(OFF_INV1):   sel = RG_INV1;
            ADDR_W'(OFF_INVALL): sel = RG_INVALL;
            ADDR_W'(OFF_SYNC):   sel = RG_SYNC;
            default:             sel = RG_NONE;
        endcase
    end

endmodule

// File: rtl/mpf_regs.sv
module mpf_regs
    import mpf_pkg::*;
#(
    parameter int DW      = 64,
    parameter int PA_W    = 52,
    parameter int IDB_W   = 5,
    parameter int IDB_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [DW-1:0]    wdata,
    output logic             irq_en,
    output logic [IDB_W-1:0] id_bits,
    output logic [PA_W-1:0]  pend_base,
    output logic [DW-1:0]    rdata
);

    localparam int PROP_LSB = 12;
    localparam int PEND_LSB = 16;
    localparam logic [PA_W-1:0] PROP_MASK = {{(PA_W-PROP_LSB){1'b1}}, {PROP_LSB{1'b0}}};
    localparam logic [PA_W-1:0] PEND_MASK = {{(PA_W-PEND_LSB){1'b1}}, {PEND_LSB{1'b0}}};
    localparam logic [IDB_W-1:0] IDB_CAP  = IDB_W'(IDB_MAX);

    logic [PA_W-1:0]  prop_base;
    logic [IDB_W-1:0] idb_in;
    logic             unused_bits;

    assign idb_in      = wdata[IDB_W-1:0];
    assign unused_bits = ^{wdata[DW-1:PA_W], wdata[PROP_LSB-1:IDB_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en    <= 1'b0;
            id_bits   <= '0;
            prop_base <= '0;
            pend_base <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RG_CTRL: irq_en <= wdata[0];
                RG_PROP: begin
                    prop_base <= wdata[PA_W-1:0] & PROP_MASK;
                    id_bits   <= (idb_in > IDB_CAP) ? IDB_CAP : idb_in;
                end
                RG_PEND: pend_base <= wdata[PA_W-1:0] & PEND_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            RG_CTRL: rdata[0]        = irq_en;
            RG_PROP: rdata[PA_W-1:0] = prop_base | PA_W'(id_bits);
            RG_PEND: rdata[PA_W-1:0] = pend_base;
            default: ;
        endcase
    end

    // R3
    idbits_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_bits <= IDB_CAP);

    // R4
    pend_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_base & ~PEND_MASK) == '0);

endmodule

// File: rtl/mpf_rmw_fsm.sv
module mpf_rmw_fsm
    import mpf_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int ID_W  = 32,
    parameter int IDB_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_set,
    input  logic [ID_W-1:0]  cmd_id,
    input  logic             irq_en,
    input  logic [IDB_W-1:0] id_bits,
    input  logic [PA_W-1:0]  pend_base,
    input  logic             mem_ready,
    input  logic [7:0]       mem_rdata,
    output logic             done_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             rescan
);

    localparam int LIM_W = ID_W + 1;

    rmw_state_e      st, st_nxt;
    logic [LIM_W-1:0] id_limit;
    logic            in_range, go;
    logic            op_set_q, chg_q;
    logic [2:0]      bit_q;
    logic [PA_W-1:0] addr_q;
    logic [7:0]      data_q, fetched_q, bit_mask;
    logic            hit, need_write;

    assign id_limit   = LIM_W'(1) << (id_bits + 1'b1);
    assign in_range   = {1'b0, cmd_id} <= id_limit;
    assign go         = cmd_valid && irq_en && in_range;
    assign bit_mask   = 8'd1 << bit_q;
    assign hit        = |(mem_rdata & bit_mask);
    assign need_write = op_set_q ? !hit : hit;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (go) st_nxt = ST_FETCH;
            ST_FETCH:  if (mem_ready) st_nxt = need_write ? ST_STORE : ST_FINISH;
            ST_STORE:  if (mem_ready) st_nxt = ST_FINISH;
            ST_FINISH: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_set_q  <= 1'b0;
            chg_q     <= 1'b0;
            bit_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            fetched_q <= '0;
        end else begin
            if (st == ST_IDLE && go) begin
                op_set_q <= cmd_set;
                bit_q    <= cmd_id[2:0];
                addr_q   <= pend_base + PA_W'(cmd_id >> 3);
                chg_q    <= 1'b0;
            end
            if (st == ST_FETCH && mem_ready) begin
                fetched_q <= mem_rdata;
                data_q    <= op_set_q ? (mem_rdata | bit_mask) : (mem_rdata & ~bit_mask);
                chg_q     <= need_write;
            end
        end
    end

    always_comb begin
        mem_req    = (st == ST_FETCH) || (st == ST_STORE);
        mem_we     = (st == ST_STORE);
        mem_addr   = addr_q;
        mem_wdata  = data_q;
        rescan     = (st == ST_FINISH) && chg_q;
        done_ready = ((st == ST_IDLE) && !go) || (st == ST_FINISH);
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9
    rescan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |=> !rescan);

    // R9
    rescan_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(mem_req && mem_we && mem_ready));

    // R7
    wr_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $countones(mem_wdata ^ fetched_q) == 1);

    // R5
    no_mem_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> irq_en);

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr - pend_base) <= PA_W'(id_limit >> 3));

endmodule

// File: rtl/msgirq_pend_front.sv
module msgirq_pend_front
    import mpf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DW      = 64,
    parameter int PA_W    = 52,
    parameter int ID_W    = 32,
    parameter int IDB_W   = 5,
    parameter int IDB_MAX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_ready,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              rescan
);

    reg_sel_e         sel;
    logic             irq_en;
    logic [IDB_W-1:0] id_bits;
    logic [PA_W-1:0]  pend_base;
    logic             cmd_valid, cmd_set, reg_wr;

    mpf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign cmd_valid = reg_req && reg_we && ((sel == RG_SETP) || (sel == RG_CLRP));
    assign cmd_set   = (sel == RG_SETP);
    assign reg_wr    = reg_req && reg_we && reg_ready;
    assign reg_err   = reg_req && reg_ready && (sel == RG_NONE);

    mpf_regs #(
        .DW(DW), .PA_W(PA_W), .IDB_W(IDB_W), .IDB_MAX(IDB_MAX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .sel       (sel),
        .wdata     (reg_wdata),
        .irq_en    (irq_en),
        .id_bits   (id_bits),
        .pend_base (pend_base),
        .rdata     (reg_rdata)
    );

    mpf_rmw_fsm #(
        .PA_W(PA_W), .ID_W(ID_W), .IDB_W(IDB_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_set    (cmd_set),
        .cmd_id     (reg_wdata[ID_W-1:0]),
        .irq_en     (irq_en),
        .id_bits    (id_bits),
        .pend_base  (pend_base),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .done_ready (reg_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rescan     (rescan)
    );

    // R12
    err_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> reg_ready && !mem_req && !rescan);

endmodule

// File: tb/msgirq_pend_front_tb_top.sv
`timescale 1ns/1ps
module msgirq_pend_front_tb_top;

    localparam logic [63:0] PBASE = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_ready, reg_err;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, rescan;
    logic [51:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    logic [7:0]  mem_arr [64];
    logic [7:0]  ref_arr [64];
    int          lat = 0;
    int          wcnt = 0;
    int          mem_acc_cnt = 0;
    int          mem_wr_cnt = 0;
    int          rescan_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    msgirq_pend_front dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ready(reg_ready), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rescan(rescan)
    );

    // Byte memory model with variable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req && mem_ready) begin
            mem_acc_cnt = mem_acc_cnt + 1;
            if (mem_we) begin
                mem_arr[6'(mem_addr - PBASE[51:0])] <= mem_wdata;
                mem_wr_cnt = mem_wr_cnt + 1;
            end
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem_arr[6'(mem_addr - PBASE[51:0])];
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    always @(negedge clk) if (rst_n && rescan) rescan_cnt = rescan_cnt + 1;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit we, input logic [7:0] a, input logic [63:0] d,
                        output logic [63:0] rd, output logic er, output int cyc);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        cyc = 0;
        #1;
        while (!reg_ready && cyc < 1000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = reg_rdata;
        er = reg_err;
        @(posedge clk);
        #1;
        reg_req = 1'b0;
        reg_we  = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        logic [63:0] rd; logic er; int cyc;
        xfer(1'b1, a, d, rd, er, cyc);
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [63:0] exp);
        logic [63:0] rd; logic er; int cyc;
        xfer(1'b0, a, 64'h0, rd, er, cyc);
        chk(tag, rd, exp);
        chk(tag, {63'b0, er}, 64'h0);
    endtask

    // One set or clear with full expectation from the reference bitmap
    task automatic do_op(bit set, logic [63:0] data, bit en_now, longint lim);
        logic [63:0] rd; logic er; int cyc;
        int a0, w0, r0, byte_i, bit_i;
        longint id;
        bit eff, cur, chg;
        id  = longint'(data[31:0]);
        eff = en_now && (id <= lim);
        lat = int'(id % 3);
        a0 = mem_acc_cnt; w0 = mem_wr_cnt; r0 = rescan_cnt;
        xfer(1'b1, set ? 8'h40 : 8'h48, data, rd, er, cyc);
        if (!eff) begin
            chk(en_now ? "R6 access" : "R5 access", 64'(mem_acc_cnt - a0), 64'h0);
            chk(en_now ? "R6 rescan" : "R5 rescan", 64'(rescan_cnt - r0), 64'h0);
            chk(en_now ? "R6 latency" : "R5 latency", 64'(cyc), 64'h0);
        end else begin
            byte_i = int'(id >> 3);
            bit_i  = int'(id % 8);
            cur    = ref_arr[byte_i][bit_i];
            chg    = set ? !cur : cur;
            ref_arr[byte_i][bit_i] = set;
            chk("R8 write count", 64'(mem_wr_cnt - w0), 64'(chg));
            chk("R8 access count", 64'(mem_acc_cnt - a0), 64'(1 + chg));
            chk("R9 rescan", 64'(rescan_cnt - r0), 64'(chg));
            chk("R7 byte", 64'(mem_arr[byte_i]), 64'(ref_arr[byte_i]));
            chk("R10 stall", 64'(cyc >= 2), 64'h1);
        end
        chk("R12 no error on set or clear", {63'b0, er}, 64'h0);
    endtask

    initial begin
        logic [63:0] rd; logic er; int cyc;
        bit defd;
        for (int i = 0; i < 64; i++) begin
            mem_arr[i] = 8'((i * 37 + 5) & 8'hFF);
            ref_arr[i] = mem_arr[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd_chk("R11 ctrl", 8'h00, 64'h0);
        rd_chk("R11 prop", 8'h70, 64'h0);
        rd_chk("R11 pend", 8'h78, 64'h0);
        rd_chk("R1 sync", 8'hC0, 64'h0);

        // Control readback
        wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R2 ctrl on", 8'h00, 64'h1);
        wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFE);
        rd_chk("R2 ctrl off", 8'h00, 64'h0);

        // Identifier width clamp sweep
        for (int v = 0; v < 32; v++) begin
            wr(8'h70, 64'hFFFF_FFFF_FFFF_FFE0 | 64'(v));
            rd_chk("R3 prop", 8'h70, 64'h000F_FFFF_FFFF_F000 | 64'((v > 15) ? 15 : v));
        end
        wr(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R4 pend", 8'h78, 64'h000F_FFFF_FFFF_0000);

        // Invalidate and synchronize are accepted without error or state change
        xfer(1'b1, 8'hA0, 64'hFFFF, rd, er, cyc);
        chk("R1 inv1 err", {63'b0, er}, 64'h0);
        xfer(1'b1, 8'hB0, 64'hFFFF, rd, er, cyc);
        chk("R1 invall err", {63'b0, er}, 64'h0);
        xfer(1'b1, 8'hC0, 64'hFFFF, rd, er, cyc);
        chk("R1 sync err", {63'b0, er}, 64'h0);
        rd_chk("R1 sync read", 8'hC0, 64'h0);
        rd_chk("R1 setp read", 8'h40, 64'h0);
        rd_chk("R1 clrp read", 8'h48, 64'h0);

        // Undefined offsets: sweep every address
        wr(8'h70, 64'h0000_0000_0003_4003);
        wr(8'h78, PBASE);
        for (int a = 0; a < 256; a++) begin
            defd = (a == 8'h00) || (a == 8'h40) || (a == 8'h48) || (a == 8'h70) ||
                   (a == 8'h78) || (a == 8'hA0) || (a == 8'hB0) || (a == 8'hC0);
            if (!defd) begin
                xfer(1'b1, 8'(a), 64'hFFFF_FFFF_FFFF_FFFF, rd, er, cyc);
                chk("R12 write err", {63'b0, er}, 64'h1);
                xfer(1'b0, 8'(a), 64'h0, rd, er, cyc);
                chk("R12 read zero", rd, 64'h0);
                chk("R12 read err", {63'b0, er}, 64'h1);
            end
        end
        rd_chk("R12 ctrl kept", 8'h00, 64'h0);
        rd_chk("R12 prop kept", 8'h70, 64'h0000_0000_0003_4003);
        rd_chk("R12 pend kept", 8'h78, PBASE);

        // Disabled: width 3, limit 16
        do_op(1'b1, 64'h3, 1'b0, 16);
        do_op(1'b0, 64'h5, 1'b0, 16);

        // Enabled sweeps: set, set again, clear, clear again
        wr(8'h00, 64'h1);
        for (int id = 0; id <= 20; id++) do_op(1'b1, 64'(id), 1'b1, 16);
        for (int id = 0; id <= 20; id++) do_op(1'b1, 64'(id), 1'b1, 16);
        for (int id = 0; id <= 20; id++) do_op(1'b0, 64'(id), 1'b1, 16);
        for (int id = 0; id <= 20; id++) do_op(1'b0, 64'(id), 1'b1, 16);

        // Width 5, limit 64; high data bits ignored
        wr(8'h70, 64'h0000_0000_0003_4005);
        do_op(1'b1, 64'hDEAD_BEEF_0000_0040, 1'b1, 64);
        do_op(1'b1, 64'hDEAD_BEEF_0000_0041, 1'b1, 64);
        do_op(1'b1, 64'h0000_0000_FFFF_FFFF, 1'b1, 64);
        do_op(1'b0, 64'h1234_0000_0000_0040, 1'b1, 64);
        for (int i = 0; i < 64; i++) chk("R7 untouched bytes", 64'(mem_arr[i]), 64'(ref_arr[i]));

        // Reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R11 ctrl after reset", 8'h00, 64'h0);
        rd_chk("R11 prop after reset", 8'h70, 64'h0);
        rd_chk("R11 pend after reset", 8'h78, 64'h0);
        do_op(1'b1, 64'h1, 1'b0, 2);

        summary();
        $finish;
    end

endmodule